// File: doc/BRIEF.md
# UART Receive Watermark Status Logic

This block produces the status seen by software and by the interrupt logic for a UART receiver. It sits beside the deserializer and the receive storage. It takes in a strobe for each completed character, the raw receive line, a start-detected pulse, the host's read strobe on the data register, the FIFO-mode select, a receive watermark and the word count reported by the FIFO. It returns three status outputs: a data-ready flag, a receiver-busy flag and a single-cycle overrun pulse. It also returns a push strobe that tells the storage whether to accept the character that just completed.

Two storage modes are supported. In FIFO mode the data-ready flag compares the external word count against the watermark with a strict greater-than test. In single-buffer mode the block tracks one buffer slot itself: a completed character fills the slot, and a host read empties it. In both modes the flag depends only on stored words, so a character that is still arriving leaves it unchanged. Reception is never stalled. A character that completes when there is no room is dropped, the stored data is left as it was, and an overrun pulse is raised.

Top module: `uart_rx_wmark_status`

## Requirements
- R1: With `fifo_en`=1, `rx_full` reads 1 in the cycle after a cycle in which `fifo_count` was strictly greater than `rx_wmark`.
- R2: With `fifo_en`=1, `rx_full` reads 0 in the cycle after a cycle in which `fifo_count` was equal to or below `rx_wmark`. A count equal to the watermark does not raise the flag.
- R3: With `fifo_en`=0, `rx_full` rises in the cycle after a stored character and drops in the cycle after `host_rd`. Start detections and line activity do not change it.
- R4: With `fifo_en`=0, a `char_done` while the buffer is held and there is no `host_rd` in the same cycle gives a one-cycle `overrun` pulse in the next cycle. A `char_done` together with `host_rd` is stored and gives no overrun.
- R5: With `fifo_en`=1, a `char_done` when `fifo_count` equals DEPTH and there is no `host_rd` gives a one-cycle `overrun` pulse in the next cycle. If `host_rd` comes in the same cycle, the character is stored instead.
- R6: `rx_push` is high in the same cycle as `char_done` exactly when there is room. On an overrun it stays low, so the stored data and the buffer state are left unchanged.
- R7: `rx_active` rises in the cycle after `start_det` while the receiver is idle.
- R8: `rx_active` falls in the cycle after `char_done` if `rx_line` is high at that time. If the line is low, the flag stays high until the first cycle in which `rx_line` is high, and falls in the cycle after that.
- R9: While reset is held, and in the cycles after its release, `rx_full`, `rx_active` and `overrun` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_done | input | 1 | A complete character has been received |
| rx_line | input | 1 | Raw receive line (idle high) |
| start_det | input | 1 | Start bit detected |
| host_rd | input | 1 | Host read of the data register |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single buffer |
| rx_wmark | input | CW | Receive watermark |
| fifo_count | input | CW+1 | Words held in the receive FIFO |
| rx_push | output | 1 | Store the completed character |
| rx_full | output | 1 | Data-ready flag |
| rx_active | output | 1 | Receiver busy |
| overrun | output | 1 | One-cycle overrun pulse |

## Verification
A character can complete in the same cycle as a host read. The room test for that cycle decides between a store and an overrun: a full single buffer or a FIFO at DEPTH must accept the character when a read frees a word. Random phases that fill storage at a high completion rate while reading with low probability reach full storage often, so the bench hits this collision many times. A bench model, updated once per cycle, predicts `rx_push`, the overrun pulse and the data-ready flag for every cycle.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;
  typedef enum logic [1:0] {
    RXS_IDLE  = 2'd0,
    RXS_BUSY  = 2'd1,
    RXS_DRAIN = 2'd2
  } rxs_state_e;
endpackage

// File: rtl/rxs_buffer_ctrl.sv
module rxs_buffer_ctrl #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          char_done,
  input  logic          host_rd,
  input  logic [CW:0]   fifo_count,
  output logic          rx_push,
  output logic          buf_full_next,
  output logic          overrun
);
  localparam logic [CW:0] FULL_LVL = (CW+1)'(DEPTH);

  logic buf_q, ovr_q, ovr_next, room, fifo_room, single_room, buf_en;

  // A read in the same cycle frees one word before the new one lands.
  always_comb begin
    fifo_room   = (fifo_count < FULL_LVL) || (host_rd && (fifo_count != '0));
    single_room = !buf_q || host_rd;
    room        = fifo_en ? fifo_room : single_room;
    rx_push     = char_done && room;
    ovr_next    = char_done && !room;
  end

  always_comb begin
    buf_en        = host_rd || (rx_push && !fifo_en);
    buf_full_next = buf_q;
    if (buf_en) begin
      buf_full_next = rx_push && !fifo_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (buf_en) buf_q <= buf_full_next;
      ovr_q <= ovr_next;
    end
  end

  assign overrun = ovr_q;

  a_r3_fill_from_char: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_q) |-> $past(char_done));
  a_r5_ovr_after_char: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(char_done));
  a_r6_ovr_not_pushed: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !$past(rx_push));
endmodule

// File: rtl/rxs_wmark_flag.sv
module rxs_wmark_flag #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [CW:0]   fifo_count,
  input  logic [CW-1:0] wmark,
  input  logic          buf_full_next,
  output logic          rx_full
);
  logic full_q, full_next, above;

  always_comb begin
    above     = fifo_count > {1'b0, wmark};
    full_next = fifo_en ? above : buf_full_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_next;
  end

  assign rx_full = full_q;

  a_r1_above_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (fifo_count > {1'b0, wmark})) |=> rx_full);
  a_r2_at_or_below_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (fifo_count <= {1'b0, wmark})) |=> !rx_full);
endmodule

// File: rtl/rxs_activity_fsm.sv
module rxs_activity_fsm
  import uart_rxs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic rx_line,
  input  logic char_done,
  output logic rx_active
);
  rxs_state_e st_q, st_next;

  always_comb begin
    st_next = st_q;
    unique case (st_q)
      RXS_IDLE:  if (start_det) st_next = RXS_BUSY;
      RXS_BUSY:  if (char_done) st_next = rx_line ? RXS_IDLE : RXS_DRAIN;
      RXS_DRAIN: if (rx_line)   st_next = RXS_IDLE;
      default:   st_next = RXS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RXS_IDLE;
    else        st_q <= st_next;
  end

  assign rx_active = (st_q != RXS_IDLE);

  a_r7_rise_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(start_det));
  a_r8_fall_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_active) |-> $past(rx_line));
endmodule

// File: rtl/uart_rx_wmark_status.sv
module uart_rx_wmark_status #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_done,
  input  logic          rx_line,
  input  logic          start_det,
  input  logic          host_rd,
  input  logic          fifo_en,
  input  logic [CW-1:0] rx_wmark,
  input  logic [CW:0]   fifo_count,
  output logic          rx_push,
  output logic          rx_full,
  output logic          rx_active,
  output logic          overrun
);
  logic rst_s1, rst_sn, buf_full_next;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  rxs_buffer_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_buf (
    .clk(clk), .rst_n(rst_sn), .fifo_en(fifo_en), .char_done(char_done),
    .host_rd(host_rd), .fifo_count(fifo_count), .rx_push(rx_push),
    .buf_full_next(buf_full_next), .overrun(overrun)
  );

  rxs_wmark_flag #(.CW(CW)) u_flag (
    .clk(clk), .rst_n(rst_sn), .fifo_en(fifo_en), .fifo_count(fifo_count),
    .wmark(rx_wmark), .buf_full_next(buf_full_next), .rx_full(rx_full)
  );

  rxs_activity_fsm u_act (
    .clk(clk), .rst_n(rst_sn), .start_det(start_det), .rx_line(rx_line),
    .char_done(char_done), .rx_active(rx_active)
  );

  a_r9_quiet_in_reset: assert property (@(posedge clk)
    !rst_sn |=> !overrun);
endmodule

// File: tb/uart_rx_wmark_status_tb.sv
module uart_rx_wmark_status_tb;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic char_done = 0, rx_line = 1, start_det = 0, host_rd = 0, fifo_en = 0;
  logic [CW-1:0] rx_wmark = '0;
  logic [CW:0]   fifo_count = '0;
  logic rx_push, rx_full, rx_active, overrun;

  int checks = 0, errors = 0;
  int cnt = 0;
  bit m_buf = 0, m_full = 0, m_ovr = 0;
  int m_st = 0;  // 0 idle, 1 busy, 2 waiting for line high

  always #2 clk = ~clk;

  uart_rx_wmark_status #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .rx_line(rx_line),
    .start_det(start_det), .host_rd(host_rd), .fifo_en(fifo_en),
    .rx_wmark(rx_wmark), .fifo_count(fifo_count), .rx_push(rx_push),
    .rx_full(rx_full), .rx_active(rx_active), .overrun(overrun)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit room_f(bit fe, int c, bit rd, bit b);
    if (fe) return (c < DEPTH) || (rd && c > 0);
    return !b || rd;
  endfunction

  // One cycle: drive at negedge, check push, advance model, check registers.
  task automatic step(input bit cd, input bit rd, input bit sd, input bit ln);
    bit push, nbuf;
    @(negedge clk);
    char_done = cd; host_rd = rd; start_det = sd; rx_line = ln;
    fifo_count = (CW+1)'(cnt);
    #1;
    push = cd && room_f(fifo_en, cnt, rd, m_buf);
    chk("R6", rx_push, push);
    nbuf = m_buf;
    if (rd) nbuf = 0;
    if (push && !fifo_en) nbuf = 1;
    m_full = fifo_en ? (cnt > int'(rx_wmark)) : nbuf;
    m_ovr = cd && !push;
    m_buf = nbuf;
    if (fifo_en) cnt = cnt - ((rd && cnt > 0) ? 1 : 0) + (push ? 1 : 0);
    case (m_st)
      0: if (sd) m_st = 1;
      1: if (cd) m_st = ln ? 0 : 2;
      default: if (ln) m_st = 0;
    endcase
    @(negedge clk);
    chk(fifo_en ? (m_full ? "R1" : "R2") : "R3", rx_full, m_full);
    chk(fifo_en ? "R5" : "R4", overrun, m_ovr);
    chk(m_st == 0 ? "R8" : "R7", rx_active, m_st != 0);
    char_done = 0; host_rd = 0; start_det = 0;
  endtask

  initial begin
    int unused;
    unused = $urandom(20240611);
    repeat (3) @(negedge clk);
    chk("R9", rx_full, 1'b0); chk("R9", rx_active, 1'b0); chk("R9", overrun, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", rx_full, 1'b0); chk("R9", rx_active, 1'b0); chk("R9", overrun, 1'b0);

    // Directed: single buffer, store, overrun, collision with a read.
    fifo_en = 0;
    step(1, 0, 0, 1);  // stored R3
    step(1, 0, 0, 1);  // dropped R4
    step(1, 1, 0, 1);  // read + char: stored R4
    step(0, 1, 0, 1);  // cleared R3
    // Directed: activity with a low line at the end of a character.
    step(0, 0, 1, 0);  // R7
    step(1, 0, 0, 0);  // stays active R8
    step(0, 0, 0, 0);
    step(0, 0, 0, 1);  // falls R8
    // Directed: FIFO watermark boundary, then fill to overrun.
    fifo_en = 1; rx_wmark = CW'(3);
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0, 1);  // R1, R2, R5
    step(1, 1, 0, 1);  // full with read: stored R5
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 1);      // drain R2

    // Random phases with biased rates.
    for (int ph = 0; ph < 12; ph++) begin
      int pcd, prd;
      fifo_en  = ph[0];
      rx_wmark = CW'($urandom_range(0, DEPTH - 1));
      pcd = ph[1] ? 2 : 5;
      prd = ph[2] ? 2 : 9;
      for (int i = 0; i < 600; i++)
        step($urandom_range(0, pcd - 1) == 0, $urandom_range(0, prd - 1) == 0,
             $urandom_range(0, 5) == 0, $urandom_range(0, 3) != 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule